// File: doc/BRIEF.md
# SDRAM Row-Open and Read Burst Sequencer

This block sits on the controller side of a single-data-rate SDRAM and serves one read request at a time. A request names a bank, a row, a starting column and whether the row is to close by itself when the burst ends. The sequencer opens the row with an ACTIVE command and issues NOP commands while the row-to-column delay runs. It then issues READ. The memory returns a burst on its data pins after the CAS latency, and the sequencer captures each word and hands it to the requester with a valid strobe.

The row-to-column wait comes from two parameters: a minimum delay in picoseconds and the clock period in picoseconds. The wait is the smallest whole number of clocks that covers the minimum. CAS latency and burst length are also parameters. The sequencer reports busy from acceptance until the last word of the burst has been taken. The memory is reached only through its command, address and data pins.

Top module: `sdr_act_rd_seq`

## Requirements
- R1: While reset is asserted, CKE is low, the command pins {cs_n, ras_n, cas_n, we_n} carry NOP (0111), busy is low and rd_valid is low. From the first clock after reset, CKE is high.
- R2: A request is accepted on a rising edge where req_valid is high and busy is low. In the cycle that follows, the command pins carry ACTIVE (0011), mem_ba carries the requested bank and mem_addr carries the requested row.
- R3: READ (0101) appears exactly RCD cycles after ACTIVE. RCD is the smallest integer x with x * TCK_PS >= TRCD_PS, and is never less than 1. With the defaults (20000 ps, 8000 ps) RCD is 3.
- R4: Every cycle between ACTIVE and READ carries NOP (0111). No command other than ACTIVE, READ or NOP is ever issued.
- R5: During READ, mem_ba carries the requested bank and mem_addr[COL_W-1:0] carries the starting column. mem_addr bit 10 carries the auto-precharge flag (1 = close the row after the burst). All other address bits are zero.
- R6: The first word is sampled from mem_dq at the rising edge that falls CAS_LAT clocks after the edge at which the memory registers READ. It is presented on rd_data with rd_valid high in the following cycle. The remaining words follow on consecutive cycles. Counted from the acceptance edge, the first rd_valid cycle comes RCD + 1 + CAS_LAT edges later.
- R7: Each accepted request yields exactly BURST_LEN rd_valid cycles, and rd_valid is never high outside a burst.
- R8: busy rises in the cycle after acceptance and falls in the cycle in which the last word is presented. While busy is high, req_valid is ignored and no ACTIVE is issued. While busy is low, the command pins carry NOP.
- R9: CKE stays high for the whole of every activate-and-read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_bank | input | BA_W | Bank to open and read |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column of the burst |
| req_auto_pre | input | 1 | Close the row after the burst |
| busy | output | 1 | A request is in progress; new requests are ignored |
| rd_valid | output | 1 | rd_data holds a burst word |
| rd_data | output | DQ_W | Captured burst word |
| mem_cke | output | 1 | Clock enable to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address to the memory |
| mem_addr | output | ADDR_W | Multiplexed row / column address |
| mem_dq | input | DQ_W | Read data from the memory |

## Verification
Two functions can land in the same cycle: the last word of one burst is presented with busy already low, and the next request is accepted on the edge that closes that cycle. The bench provokes this by raising req_valid for the following request at the very sample where it sees the final rd_valid. This gives every one of the 32 sweep requests a back-to-back start. It then judges the overlap through the memory stub and the data: the new ACTIVE must keep its exact spacing to READ, and its burst must return correct, column-indexed words at the expected latency. Across the whole run, the number of strobes must equal the burst length times the number of requests.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  // command encoding on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_DATA
  } seq_state_e;

  // whole clocks covering a minimum delay: ceiling division, at least one
  function automatic int unsigned clocks_for(input int unsigned min_ps,
                                             input int unsigned tck_ps);
    int unsigned n;
    n = (min_ps + tck_ps - 1) / tck_ps;
    if (n == 0) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
  import sdr_seq_pkg::*;
#(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned ROW_W  = 11,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned AP_BIT = 10,
  parameter int unsigned RCD    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_auto_pre,
  input  logic              burst_done,
  output sdr_cmd_e          cmd_q,
  output logic [BA_W-1:0]   ba_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              busy,
  output logic              rd_fire
);

  localparam int unsigned GW = $clog2(RCD + 1);

  seq_state_e        state;
  logic [GW-1:0]     gap_q;
  logic [COL_W-1:0]  col_q;
  logic              ap_q;
  logic [ADDR_W-1:0] row_addr;
  logic [ADDR_W-1:0] col_addr;

  // row on the address bus for ACTIVE
  always_comb begin
    row_addr = '0;
    row_addr[ROW_W-1:0] = req_row;
  end

  // column plus precharge flag for READ
  always_comb begin
    col_addr = '0;
    col_addr[COL_W-1:0] = col_q;
    col_addr[AP_BIT] = ap_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      gap_q  <= '0;
      col_q  <= '0;
      ap_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cmd_q <= CMD_NOP;
          if (accept) begin
            cmd_q  <= CMD_ACT;
            ba_q   <= req_bank;
            addr_q <= row_addr;
            col_q  <= req_col;
            ap_q   <= req_auto_pre;
            gap_q  <= GW'(RCD - 1);
            state  <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_q == '0) begin
            cmd_q  <= CMD_RD;
            addr_q <= col_addr;
            state  <= ST_DATA;
          end else begin
            cmd_q <= CMD_NOP;
            gap_q <= gap_q - 1'b1;
          end
        end
        ST_DATA: begin
          cmd_q <= CMD_NOP;
          if (burst_done) state <= ST_IDLE;
        end
        default: begin
          cmd_q <= CMD_NOP;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign rd_fire = (cmd_q == CMD_RD);

endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
  parameter int unsigned DQ_W = 32,
  parameter int unsigned CL   = 2,
  parameter int unsigned BL   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_fire,
  input  logic [DQ_W-1:0] dq_in,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data,
  output logic            burst_done
);

  localparam int unsigned BCW = (BL > 1) ? $clog2(BL) : 1;

  logic [CL-1:0]  lat_sr;
  logic [BCW-1:0] beat_q;
  logic           in_burst;
  logic           capture_en;

  // one stage per clock of CAS latency; the memory registers READ one
  // edge after the command register loads it, so CL stages line up the
  // first capture with the first valid word
  generate
    if (CL == 1) begin : g_lat1
      always_ff @(posedge clk) begin
        if (!rst_n) lat_sr <= '0;
        else        lat_sr <= rd_fire;
      end
    end else begin : g_latn
      always_ff @(posedge clk) begin
        if (!rst_n) lat_sr <= '0;
        else        lat_sr <= {lat_sr[CL-2:0], rd_fire};
      end
    end
  endgenerate

  assign capture_en = lat_sr[CL-1] | in_burst;
  assign burst_done = capture_en && (beat_q == BCW'(BL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      beat_q   <= '0;
      in_burst <= 1'b0;
    end else if (capture_en) begin
      rd_valid <= 1'b1;
      rd_data  <= dq_in;
      if (beat_q == BCW'(BL - 1)) begin
        beat_q   <= '0;
        in_burst <= 1'b0;
      end else begin
        beat_q   <= beat_q + 1'b1;
        in_burst <= 1'b1;
      end
    end else begin
      rd_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sdr_act_rd_seq.sv
module sdr_act_rd_seq
  import sdr_seq_pkg::*;
#(
  parameter int unsigned TCK_PS    = 8000,
  parameter int unsigned TRCD_PS   = 20000,
  parameter int unsigned CAS_LAT   = 2,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned ROW_W     = 11,
  parameter int unsigned COL_W     = 8,
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned AP_BIT    = 10,
  parameter int unsigned DQ_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_auto_pre,
  output logic              busy,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DQ_W-1:0]   mem_dq
);

  localparam int unsigned RCD_CLK = clocks_for(TRCD_PS, TCK_PS);

  // named internal events
  logic     accept;
  logic     rd_fire;
  logic     burst_done;
  logic     cke_q;
  sdr_cmd_e cmd_q;

  assign accept = req_valid & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b0;
    else        cke_q <= 1'b1;
  end

  sdr_seq_ctrl #(
    .BA_W  (BA_W),
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .ADDR_W(ADDR_W),
    .AP_BIT(AP_BIT),
    .RCD   (RCD_CLK)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .req_bank    (req_bank),
    .req_row     (req_row),
    .req_col     (req_col),
    .req_auto_pre(req_auto_pre),
    .burst_done  (burst_done),
    .cmd_q       (cmd_q),
    .ba_q        (mem_ba),
    .addr_q      (mem_addr),
    .busy        (busy),
    .rd_fire     (rd_fire)
  );

  sdr_rd_capture #(
    .DQ_W(DQ_W),
    .CL  (CAS_LAT),
    .BL  (BURST_LEN)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_fire),
    .dq_in     (mem_dq),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .burst_done(burst_done)
  );

  assign mem_cke = cke_q;
  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;

endmodule

// File: rtl/sdr_act_rd_seq_chk.sv
module sdr_act_rd_seq_chk #(
  parameter int unsigned RCD    = 3,
  parameter int unsigned BL     = 4,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned AP_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic [BA_W-1:0]   req_bank,
  input logic              req_auto_pre,
  input logic [3:0]        cmd,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              cke,
  input logic              busy,
  input logic              rd_valid
);

  logic [15:0] since_act;
  logic [15:0] beats;
  logic        ap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= '0;
      beats     <= '0;
      ap_q      <= 1'b0;
    end else begin
      if (cmd == 4'b0011)                       since_act <= 16'd1;
      else if (since_act != 0 && since_act <= 16'(RCD)) since_act <= since_act + 1'b1;
      if (accept) begin
        beats <= '0;
        ap_q  <= req_auto_pre;
      end else if (rd_valid) begin
        beats <= beats + 1'b1;
      end
    end
  end

  p_act_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cmd == 4'b0011 && ba == $past(req_bank)));

  p_read_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0101) |-> (since_act == 16'(RCD)));

  p_gap_nop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_act != 0 && since_act < 16'(RCD)) |-> (cmd == 4'b0111));

  p_ap_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0101) |-> (addr[AP_BIT] == ap_q));

  p_beat_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (rd_valid && beats == 16'(BL - 1)));

  p_idle_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd == 4'b0111));

  p_cke_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cke);

endmodule

bind sdr_act_rd_seq sdr_act_rd_seq_chk #(
  .RCD   (RCD_CLK),
  .BL    (BURST_LEN),
  .BA_W  (BA_W),
  .ADDR_W(ADDR_W),
  .AP_BIT(AP_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .req_bank    (req_bank),
  .req_auto_pre(req_auto_pre),
  .cmd         ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}),
  .ba          (mem_ba),
  .addr        (mem_addr),
  .cke         (mem_cke),
  .busy        (busy),
  .rd_valid    (rd_valid)
);

// File: tb/test_sdr_act_rd_seq.sv
`timescale 1ns/1ps
module test_sdr_act_rd_seq;

  localparam int TCK  = 8000;
  localparam int TRCD = 20000;
  localparam int CL   = 2;
  localparam int BL   = 4;
  localparam int COLW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [10:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic        req_auto_pre = 1'b0;
  logic        busy, rd_valid;
  logic [31:0] rd_data;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [10:0] addr;
  logic [31:0] dq = '0;

  always #10 clk = ~clk;

  sdr_act_rd_seq i_sdr_act_rd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_auto_pre(req_auto_pre),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_cke(cke), .mem_cs_n(cs_n), .mem_ras_n(ras_n), .mem_cas_n(cas_n),
    .mem_we_n(we_n), .mem_ba(ba), .mem_addr(addr), .mem_dq(dq)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, exp_rcd = 0, n_req = 0;
  int act_cnt = 0, act_edge = -100, rd_edge = -100, rd_gap = 0;
  int gap_bad = 0, cke_bad = 0, valid_seen = 0;
  logic [1:0]  act_ba, rd_ba;
  logic [10:0] act_row;
  logic [7:0]  rd_col;
  logic        rd_ap, rd_hi_zero, in_gap = 1'b0;

  function automatic int burst_col(int c, int i);
    return ((c & ~(BL - 1)) | ((c + i) & (BL - 1))) & 255;
  endfunction

  function automatic logic [31:0] mem_word(int b, int r, int c);
    logic [1:0] bb = b[1:0]; logic [10:0] rr = r[10:0]; logic [7:0] cc = c[7:0];
    return {bb, rr, cc, 11'h2C5};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n && rd_valid) valid_seen++;

  // behavioural memory stub: records commands, returns column-indexed bursts
  always @(posedge clk) begin
    logic [3:0]  c;
    logic [10:0] hi;
    c = {cs_n, ras_n, cas_n, we_n};
    if (rst_n) begin
      if (busy && !cke) cke_bad++;
      if (in_gap && c != 4'b0111 && c != 4'b0101) gap_bad++;
      if (c != 4'b0111 && c != 4'b0101 && c != 4'b0011) gap_bad++;
      if (c == 4'b0011) begin
        act_cnt++; act_edge = cyc; act_ba = ba; act_row = addr; in_gap = 1'b1;
      end
      if (c == 4'b0101) begin
        rd_gap = cyc - act_edge; rd_edge = cyc; rd_ba = ba;
        rd_col = addr[COLW-1:0]; rd_ap = addr[10]; in_gap = 1'b0;
        hi = addr; hi[10] = 1'b0; hi[COLW-1:0] = '0; rd_hi_zero = (hi == '0);
      end
    end
    if (cyc >= rd_edge + CL - 1 && cyc < rd_edge + CL - 1 + BL)
      dq <= mem_word(rd_ba, act_row, burst_col(rd_col, cyc - rd_edge - CL + 1));
    else
      dq <= 32'hBAD0_0000 | 32'(cyc & 16'hFFFF);
  end

  task automatic do_req(input int b, input int r, input int c, input int a, input bit poke);
    int a0, c0, got, t;
    while (busy) @(negedge clk);
    a0 = act_cnt;
    req_valid = 1'b1; req_bank = b[1:0]; req_row = r[10:0]; req_col = c[7:0]; req_auto_pre = a[0];
    @(negedge clk);
    req_valid = 1'b0;
    c0 = cyc;
    n_req++;
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    got = 0; t = 0;
    while (got < BL && t < 60) begin
      if (poke && t == 1) begin req_valid = 1'b1; req_bank = b[1:0] ^ 2'd1; end
      if (poke && t == 4) req_valid = 1'b0;
      @(negedge clk); t++;
      if (rd_valid) begin
        if (got == 0) chk(cyc == c0 + exp_rcd + 1 + CL, "R6 first word latency", cyc - c0, exp_rcd + 1 + CL);
        chk(rd_data == mem_word(b, r, burst_col(c, got)), "R6 burst word", rd_data, mem_word(b, r, burst_col(c, got)));
        got++;
        if (got == BL) chk(busy == 1'b0, "R8 busy falls with last word", busy, 0);
        else           chk(busy == 1'b1, "R8 busy held during burst", busy, 1);
      end
    end
    chk(got == BL, "R7 words per request", got, BL);
    chk(act_cnt == a0 + 1, poke ? "R8 request ignored while busy" : "R2 one ACTIVE", act_cnt - a0, 1);
    chk(act_ba == b[1:0] && act_row == r[10:0], "R2 ACTIVE bank/row", {act_ba, act_row}, {b[1:0], r[10:0]});
    chk(rd_gap == exp_rcd, "R3 ACTIVE to READ spacing", rd_gap, exp_rcd);
    chk(rd_ba == b[1:0] && rd_col == c[7:0], "R5 READ bank/column", {rd_ba, rd_col}, {b[1:0], c[7:0]});
    chk(rd_ap == a[0], "R5 auto-precharge bit", rd_ap, a);
    chk(rd_hi_zero, "R5 unused address bits zero", rd_hi_zero, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    exp_rcd = 1;
    while (exp_rcd * TCK < TRCD) exp_rcd++;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cke == 1'b0, "R1 CKE low in reset", cke, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 NOP in reset", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(busy == 1'b0 && rd_valid == 1'b0, "R1 idle outputs in reset", {busy, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cke == 1'b1, "R1 CKE high after reset", cke, 1);
    chk(exp_rcd == 3, "R3 derived spacing", exp_rcd, 3);
    // sweep: all banks, both precharge settings, edge and interior rows/columns
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 2; a++)
        for (int k = 0; k < 4; k++)
          do_req(b, (k == 0) ? 0 : (k == 3) ? 2047 : b * 300 + k * 77,
                 (k == 0) ? 0 : (k == 1) ? 255 : (k * 37 + b * 5 + a) & 255, a, 1'b0);
    // R8 request held high while busy is ignored
    do_req(2, 1234, 77, 1, 1'b1);
    do_req(1, 5, 250, 0, 1'b1);
    repeat (8) @(negedge clk);
    chk(valid_seen == n_req * BL, "R7 total strobes", valid_seen, n_req * BL);
    chk(gap_bad == 0, "R4 NOP between ACTIVE and READ", gap_bad, 0);
    chk(cke_bad == 0, "R9 CKE high while busy", cke_bad, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111 && !busy, "R8 idle NOP", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule